// File: doc/BRIEF.md
# Li-ion Charge Sequencing Controller

This block is the digital sequencer of a single-cell lithium charger. It walks each charge cycle through a slow preconditioning phase, a constant-current phase and a constant-voltage phase. It then either settles into an idle wait for the battery to sag, or it latches a fault. The analog loop reports the battery and programming-pin conditions as comparator flags. A slow oscillator supplies a one-clock tick. The controller answers with a mode code for the regulation loop and two active-low indication lines.

All flags are sampled into a register before the sequencer uses them. A single safety timer counts ticks. It bounds the preconditioning phase at one eighth of its full span. On entry to constant current it restarts and then bounds constant current and constant voltage together. A separate small counter checks that the battery voltage has stayed above its minimum for a run of consecutive ticks before fast charging is allowed.

Top module: `chg_seq_ctrl`

## Requirements
- R1: Mode codes are OFF=0, TRICKLE=1, CC=2, CV=3, INHIBIT=4, LATCHED=5, PROG_HOLD=6. While reset is high, or while enable is low, the mode is OFF and both `status_n_o` and `fault_n_o` are 1. After reset releases with enable high, or when enable rises, a new cycle starts in TRICKLE with `status_n_o`=0 and `fault_n_o`=1.
- R2: TRICKLE moves to CC only on the QUAL_TICKS-th (default 15) consecutive tick on which the above-minimum flag is set. A tick with the flag clear restarts the run.
- R3: If 2^(TIMER_W-3) ticks pass in TRICKLE without qualifying, the mode becomes LATCHED with `fault_n_o`=0 and `status_n_o`=1.
- R4: In CC, a set at-charge-voltage flag moves the mode to CV. CV is entered from no other mode.
- R5: In CV, end-of-charge is qualified when the below-end-of-charge flag is set and the below-recharge flag is clear. `status_n_o` then goes to 1 and stays there while the mode stays CV, even after the current flag clears.
- R6: The timer restarts on entry to CC. The 2^TIMER_W-th tick after that entry, in CC or CV, moves the mode to INHIBIT (both indications 1) if end-of-charge has been qualified, and to LATCHED otherwise.
- R7: In LATCHED, ticks, comparator flags and the programming-pin flag have no effect. Only reset, or enable low followed by enable high, releases it into a new TRICKLE cycle.
- R8: INHIBIT holds under ticks while the below-recharge flag is clear. When that flag sets, a new cycle starts in TRICKLE with `status_n_o`=0. The safety timer is restarted for that cycle.
- R9: In any mode other than LATCHED, a set programming-out-of-range flag forces PROG_HOLD with `fault_n_o`=0 and `status_n_o`=1. When the flag clears, a new TRICKLE cycle starts without any latch.
- R10: A comparator flag change made between clock edges changes the mode at the second rising edge after it, not the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, acts as power-on reset |
| tick_i | input | 1 | One-clock pulse per oscillator period |
| en_i | input | 1 | Charger enable, 1 = enabled |
| above_min_i | input | 1 | Sense voltage above the minimum fast-charge level |
| at_chg_i | input | 1 | Sense voltage at or above the charge voltage |
| below_rchg_i | input | 1 | Sense voltage below the recharge level |
| below_eoc_i | input | 1 | Charge current below the end-of-charge level |
| prog_oor_i | input | 1 | Current-programming pin out of its valid range |
| mode_o | output | 3 | Charge mode code (see R1) |
| status_n_o | output | 1 | Active-low charging indication |
| fault_n_o | output | 1 | Active-low fault indication |

## Verification
The properties assume that `tick_i` is a single-clock pulse. They also assume that the flags behave as levels, so a registered flag stands for the condition the sequencer decided on. The stimulus changes every input at a falling edge. It raises the tick for exactly one clock with at least one idle clock between ticks. After any flag change it waits for the register stage before it issues a tick, so every tick is judged against settled flags. The timer is shortened through TIMER_W so that full expiry paths are reached quickly.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic [2:0] {
        MODE_OFF       = 3'd0,
        MODE_TRICKLE   = 3'd1,
        MODE_CC        = 3'd2,
        MODE_CV        = 3'd3,
        MODE_INHIBIT   = 3'd4,
        MODE_LATCHED   = 3'd5,
        MODE_PROG_HOLD = 3'd6
    } chg_mode_e;

    typedef struct packed {
        logic en;
        logic above_min;
        logic at_chg;
        logic below_rchg;
        logic below_eoc;
        logic prog_oor;
    } chg_flags_t;

    typedef struct packed {
        logic clr;
        logic adv;
    } cnt_ctl_t;

    localparam cnt_ctl_t CTL_IDLE = '{clr: 1'b0, adv: 1'b0};
    localparam cnt_ctl_t CTL_CLR  = '{clr: 1'b1, adv: 1'b0};
    localparam cnt_ctl_t CTL_ADV  = '{clr: 1'b0, adv: 1'b1};

    function automatic logic mode_is_charging(chg_mode_e m);
        return (m == MODE_TRICKLE) || (m == MODE_CC) || (m == MODE_CV);
    endfunction

    function automatic logic mode_is_fault(chg_mode_e m);
        return (m == MODE_LATCHED) || (m == MODE_PROG_HOLD);
    endfunction

endpackage

// File: rtl/chg_flag_reg.sv
module chg_flag_reg
    import chg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chg_flags_t raw_i,
    output chg_flags_t flg_o,
    output logic       en_prev_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_o     <= '0;
            en_prev_o <= 1'b0;
        end else begin
            flg_o     <= raw_i;
            en_prev_o <= flg_o.en;
        end
    end

endmodule

// File: rtl/chg_qual_cnt.sv
module chg_qual_cnt
    import chg_pkg::*;
#(
    parameter int QUAL_TICKS = 15
) (
    input  logic     clk,
    input  logic     rst,
    input  cnt_ctl_t ctl_i,
    output logic     last_o
);

    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(QUAL_TICKS - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || ctl_i.clr) begin
            run_q <= '0;
        end else if (ctl_i.adv && (run_q != LAST_VAL)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign last_o = (run_q == LAST_VAL);

endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
    import chg_pkg::*;
#(
    parameter int TIMER_W       = 22,
    parameter int TRICKLE_SHIFT = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  cnt_ctl_t ctl_i,
    output logic     full_end_o,
    output logic     trickle_end_o
);

    localparam int TR_W = TIMER_W - TRICKLE_SHIFT;
    localparam logic [TIMER_W-1:0] TRICKLE_LAST = {{TRICKLE_SHIFT{1'b0}}, {TR_W{1'b1}}};

    logic [TIMER_W-1:0] span_q;

    always_ff @(posedge clk) begin
        if (rst || ctl_i.clr) begin
            span_q <= '0;
        end else if (ctl_i.adv) begin
            span_q <= span_q + 1'b1;
        end
    end

    assign full_end_o    = &span_q;
    assign trickle_end_o = (span_q == TRICKLE_LAST);

endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
    import chg_pkg::*;
#(
    parameter int TIMER_W       = 22,
    parameter int QUAL_TICKS    = 15,
    parameter int TRICKLE_SHIFT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       en_i,
    input  logic       above_min_i,
    input  logic       at_chg_i,
    input  logic       below_rchg_i,
    input  logic       below_eoc_i,
    input  logic       prog_oor_i,
    output logic [2:0] mode_o,
    output logic       status_n_o,
    output logic       fault_n_o
);

    chg_flags_t raw;
    chg_flags_t flg;
    logic       en_prev;

    assign raw = '{en:         en_i,
                   above_min:  above_min_i,
                   at_chg:     at_chg_i,
                   below_rchg: below_rchg_i,
                   below_eoc:  below_eoc_i,
                   prog_oor:   prog_oor_i};

    chg_flag_reg u_flags (
        .clk       (clk),
        .rst       (rst),
        .raw_i     (raw),
        .flg_o     (flg),
        .en_prev_o (en_prev)
    );

    cnt_ctl_t qual_ctl;
    cnt_ctl_t tmr_ctl;
    logic     qual_last;
    logic     tmr_full_end;
    logic     tmr_trickle_end;

    chg_qual_cnt #(
        .QUAL_TICKS (QUAL_TICKS)
    ) u_qual (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (qual_ctl),
        .last_o (qual_last)
    );

    chg_safety_timer #(
        .TIMER_W       (TIMER_W),
        .TRICKLE_SHIFT (TRICKLE_SHIFT)
    ) u_timer (
        .clk           (clk),
        .rst           (rst),
        .ctl_i         (tmr_ctl),
        .full_end_o    (tmr_full_end),
        .trickle_end_o (tmr_trickle_end)
    );

    chg_mode_e mode_q, mode_d;
    logic      eoc_q, eoc_d;
    logic      en_rise;
    logic      eoc_seen;

    assign en_rise  = flg.en & ~en_prev;
    assign eoc_seen = flg.below_eoc & ~flg.below_rchg;

    always_comb begin
        mode_d   = mode_q;
        eoc_d    = eoc_q;
        qual_ctl = CTL_IDLE;
        tmr_ctl  = CTL_IDLE;

        if (!flg.en) begin
            mode_d   = MODE_OFF;
            eoc_d    = 1'b0;
            qual_ctl = CTL_CLR;
            tmr_ctl  = CTL_CLR;
        end else if (en_rise) begin
            mode_d   = MODE_TRICKLE;
            eoc_d    = 1'b0;
            qual_ctl = CTL_CLR;
            tmr_ctl  = CTL_CLR;
        end else if (mode_q == MODE_LATCHED) begin
            qual_ctl = CTL_CLR;
            tmr_ctl  = CTL_CLR;
        end else if (flg.prog_oor) begin
            mode_d   = MODE_PROG_HOLD;
            eoc_d    = 1'b0;
            qual_ctl = CTL_CLR;
            tmr_ctl  = CTL_CLR;
        end else begin
            unique case (mode_q)
                MODE_OFF, MODE_PROG_HOLD: begin
                    mode_d   = MODE_TRICKLE;
                    eoc_d    = 1'b0;
                    qual_ctl = CTL_CLR;
                    tmr_ctl  = CTL_CLR;
                end
                MODE_TRICKLE: begin
                    if (tick_i) begin
                        if (flg.above_min && qual_last) begin
                            mode_d   = MODE_CC;
                            qual_ctl = CTL_CLR;
                            tmr_ctl  = CTL_CLR;
                        end else begin
                            qual_ctl = flg.above_min ? CTL_ADV : CTL_CLR;
                            if (tmr_trickle_end) begin
                                mode_d  = MODE_LATCHED;
                                tmr_ctl = CTL_CLR;
                            end else begin
                                tmr_ctl = CTL_ADV;
                            end
                        end
                    end
                end
                MODE_CC: begin
                    if (tick_i && tmr_full_end) begin
                        mode_d  = MODE_LATCHED;
                        tmr_ctl = CTL_CLR;
                    end else begin
                        if (tick_i) begin
                            tmr_ctl = CTL_ADV;
                        end
                        if (flg.at_chg) begin
                            mode_d = MODE_CV;
                        end
                    end
                end
                MODE_CV: begin
                    if (eoc_seen) begin
                        eoc_d = 1'b1;
                    end
                    if (tick_i && tmr_full_end) begin
                        tmr_ctl = CTL_CLR;
                        mode_d  = (eoc_q || eoc_seen) ? MODE_INHIBIT : MODE_LATCHED;
                    end else if (tick_i) begin
                        tmr_ctl = CTL_ADV;
                    end
                end
                MODE_INHIBIT: begin
                    tmr_ctl = CTL_CLR;
                    if (flg.below_rchg) begin
                        mode_d   = MODE_TRICKLE;
                        eoc_d    = 1'b0;
                        qual_ctl = CTL_CLR;
                    end
                end
                default: begin
                    mode_d   = MODE_OFF;
                    eoc_d    = 1'b0;
                    qual_ctl = CTL_CLR;
                    tmr_ctl  = CTL_CLR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            eoc_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            eoc_q  <= eoc_d;
        end
    end

    assign mode_o     = mode_q;
    assign status_n_o = ~mode_is_charging(mode_q) | eoc_q;
    assign fault_n_o  = ~mode_is_fault(mode_q);

endmodule

// File: rtl/chg_seq_checks.sv
module chg_seq_checks
    import chg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic [2:0] mode_i,
    input logic       status_n_i,
    input logic       fault_n_i,
    input logic       en_q,
    input logic       en_prev,
    input logic       above_q,
    input logic       prog_q
);

    p_disabled_off_r1: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> (mode_i == MODE_OFF));

    p_trickle_ind_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_TRICKLE) |-> (!status_n_i && fault_n_i));

    p_cc_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_CC && $past(mode_i) == MODE_TRICKLE) |-> ($past(tick_i) && $past(above_q)));

    p_fault_ind_r3: assert property (@(posedge clk) disable iff (rst)
        !fault_n_i |-> status_n_i);

    p_cv_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_CV && $past(mode_i) != MODE_CV) |-> ($past(mode_i) == MODE_CC));

    p_inhibit_ind_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_INHIBIT) |-> (status_n_i && fault_n_i));

    p_latch_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_LATCHED && en_q && en_prev) |=> (mode_i == MODE_LATCHED));

    p_prog_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (prog_q && en_q && en_prev && mode_i != MODE_LATCHED) |=> (mode_i == MODE_PROG_HOLD));

endmodule

bind chg_seq_ctrl chg_seq_checks u_checks (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .mode_i     (mode_o),
    .status_n_i (status_n_o),
    .fault_n_i  (fault_n_o),
    .en_q       (flg.en),
    .en_prev    (en_prev),
    .above_q    (flg.above_min),
    .prog_q     (flg.prog_oor)
);

// File: tb/tb_chg_seq_ctrl.sv
module tb_chg_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int TW         = 8;
    localparam int QT         = 15;
    localparam int FULL       = 1 << TW;
    localparam int TRL        = 1 << (TW - 3);

    localparam logic [2:0] M_OFF  = 3'd0;
    localparam logic [2:0] M_TRK  = 3'd1;
    localparam logic [2:0] M_CC   = 3'd2;
    localparam logic [2:0] M_CV   = 3'd3;
    localparam logic [2:0] M_INH  = 3'd4;
    localparam logic [2:0] M_LAT  = 3'd5;
    localparam logic [2:0] M_PROG = 3'd6;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       tick  = 1'b0;
    logic       en    = 1'b1;
    logic       above = 1'b0;
    logic       atchg = 1'b0;
    logic       brchg = 1'b0;
    logic       beoc  = 1'b0;
    logic       prog  = 1'b0;
    logic [2:0] mode;
    logic       st_n;
    logic       ft_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    chg_seq_ctrl #(
        .TIMER_W    (TW),
        .QUAL_TICKS (QT)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .en_i         (en),
        .above_min_i  (above),
        .at_chg_i     (atchg),
        .below_rchg_i (brchg),
        .below_eoc_i  (beoc),
        .prog_oor_i   (prog),
        .mode_o       (mode),
        .status_n_o   (st_n),
        .fault_n_o    (ft_n)
    );

    task automatic chk(input string req, input logic [2:0] em, input logic es, input logic ef);
        n_checks++;
        if (mode !== em || st_n !== es || ft_n !== ef) begin
            n_fail++;
            $display("FAIL %s: got mode=%0d status_n=%0b fault_n=%0b, expected mode=%0d status_n=%0b fault_n=%0b",
                     req, mode, st_n, ft_n, em, es, ef);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic restart_cycle();
        en = 1'b0;
        clocks(3);
        en = 1'b1;
        clocks(3);
    endtask

    task automatic qualify();
        above = 1'b1;
        clocks(2);
        ticks(QT);
    endtask

    task automatic t_reset();
        clocks(3);
        chk("R1 during reset", M_OFF, 1'b1, 1'b1);
        rst = 1'b0;
        clocks(3);
        chk("R1 cycle after reset", M_TRK, 1'b0, 1'b1);
        en = 1'b0;
        clocks(3);
        chk("R1 enable low", M_OFF, 1'b1, 1'b1);
        en = 1'b1;
        clocks(3);
        chk("R1 enable rise", M_TRK, 1'b0, 1'b1);
    endtask

    task automatic t_qualify();
        restart_cycle();
        above = 1'b1;
        clocks(2);
        ticks(QT - 1);
        chk("R2 one tick short", M_TRK, 1'b0, 1'b1);
        ticks(1);
        chk("R2 qualified", M_CC, 1'b0, 1'b1);
    endtask

    task automatic t_qual_restart();
        restart_cycle();
        above = 1'b1;
        clocks(2);
        ticks(10);
        above = 1'b0;
        clocks(2);
        ticks(1);
        chk("R2 low tick", M_TRK, 1'b0, 1'b1);
        above = 1'b1;
        clocks(2);
        ticks(QT - 1);
        chk("R2 run restarted", M_TRK, 1'b0, 1'b1);
        ticks(1);
        chk("R2 requalified", M_CC, 1'b0, 1'b1);
    endtask

    task automatic t_trickle_limit();
        restart_cycle();
        above = 1'b0;
        clocks(2);
        ticks(TRL - 1);
        chk("R3 before limit", M_TRK, 1'b0, 1'b1);
        ticks(1);
        chk("R3 limit fault", M_LAT, 1'b1, 1'b0);
        above = 1'b1;
        atchg = 1'b1;
        brchg = 1'b1;
        beoc  = 1'b1;
        clocks(2);
        ticks(20);
        chk("R7 flags ignored", M_LAT, 1'b1, 1'b0);
        prog = 1'b1;
        clocks(3);
        chk("R7 prog ignored", M_LAT, 1'b1, 1'b0);
        prog  = 1'b0;
        atchg = 1'b0;
        brchg = 1'b0;
        beoc  = 1'b0;
        above = 1'b0;
        rst = 1'b1;
        clocks(2);
        rst = 1'b0;
        clocks(3);
        chk("R7 reset release", M_TRK, 1'b0, 1'b1);
    endtask

    task automatic t_cv_eoc_inhibit();
        restart_cycle();
        qualify();
        chk("R2 into cc", M_CC, 1'b0, 1'b1);
        ticks(5);
        atchg = 1'b1;
        @(negedge clk);
        chk("R10 one edge", M_CC, 1'b0, 1'b1);
        @(negedge clk);
        chk("R4 R10 cv entered", M_CV, 1'b0, 1'b1);
        atchg = 1'b0;
        beoc  = 1'b1;
        brchg = 1'b1;
        clocks(3);
        chk("R5 below recharge blocks", M_CV, 1'b0, 1'b1);
        brchg = 1'b0;
        clocks(3);
        chk("R5 eoc qualified", M_CV, 1'b1, 1'b1);
        beoc = 1'b0;
        clocks(3);
        chk("R5 eoc latched", M_CV, 1'b1, 1'b1);
        ticks(FULL - 1 - 5);
        chk("R6 one tick before expiry", M_CV, 1'b1, 1'b1);
        ticks(1);
        chk("R6 expiry to inhibit", M_INH, 1'b1, 1'b1);
        ticks(10);
        chk("R8 inhibit holds", M_INH, 1'b1, 1'b1);
        brchg = 1'b1;
        clocks(3);
        chk("R8 recharge start", M_TRK, 1'b0, 1'b1);
        brchg = 1'b0;
        qualify();
        chk("R8 second cc", M_CC, 1'b0, 1'b1);
        ticks(FULL - 1);
        chk("R6 timer restarted", M_CC, 1'b0, 1'b1);
        ticks(1);
        chk("R6 expiry without eoc", M_LAT, 1'b1, 1'b0);
        en = 1'b0;
        clocks(3);
        chk("R7 disable", M_OFF, 1'b1, 1'b1);
        en = 1'b1;
        clocks(3);
        chk("R7 enable release", M_TRK, 1'b0, 1'b1);
    endtask

    task automatic t_prog();
        restart_cycle();
        qualify();
        prog = 1'b1;
        clocks(3);
        chk("R9 prog fault", M_PROG, 1'b1, 1'b0);
        ticks(5);
        chk("R9 prog hold", M_PROG, 1'b1, 1'b0);
        prog = 1'b0;
        clocks(3);
        chk("R9 prog resume", M_TRK, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_qualify();
        t_qual_restart();
        t_trickle_limit();
        t_cv_eoc_inhibit();
        t_prog();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule